// File: doc/BRIEF.md
# Character Display Transmit Port

This block sits on a 16-bit processor memory bus and hands characters, one at a time, to a display engine. Software sees two registers at fixed addresses. The status register at 16'hFE04 reports whether the port can take a character and holds an interrupt-enable bit. The data register at 16'hFE06 takes the character to send.

A store to the data register while the port is ready does three things. It latches the low byte of the store. It raises a one-cycle valid strobe toward the display. It drops the ready flag. The port then counts as busy until the display returns a one-cycle done pulse. Stores to the data register made while busy are dropped silently and do not stall the bus.

On the display side the flow control is completion-based rather than level-based. The port never re-sends or holds the strobe, and it holds back its next strobe until done has arrived. The display must therefore take the byte in the strobe cycle, and it signals back-pressure only by delaying done. An interrupt request is raised whenever the port is ready and software has set the enable bit.

Top module: `dsp_port`

## Requirements
- R1: After reset the port is ready, the interrupt enable is 0, the held character is 8'h00, disp_valid is 0 and irq is 0.
- R2: A read (bus_sel=1, bus_we=0) of address 16'hFE04 returns the ready flag in bit 15, the interrupt enable in bit 14, and zero in bits 13:0, in the same cycle.
- R3: A write to 16'hFE06 while ready is 1 has these effects from the next cycle on: ready is 0, disp_char equals bits 7:0 of the written word, and disp_valid is 1 for exactly that one cycle.
- R4: A write to 16'hFE06 while ready is 0 is ignored: disp_char keeps its value and disp_valid stays 0.
- R5: A disp_done pulse while ready is 0 sets ready to 1 in the next cycle. A disp_done pulse while ready is 1 has no effect.
- R6: A write to 16'hFE04 loads bit 14 of the written word into the interrupt enable and leaves the ready flag unchanged.
- R7: irq is 1 exactly when ready is 1 and the interrupt enable is 1.
- R8: A read of 16'hFE06 returns the last accepted character in bits 7:0, with bits 15:8 zero.
- R9: A read of any other address returns zero, and a write to any other address changes no state.
- R10: bus_rdata is zero in any cycle that is not a read (bus_sel=0 or bus_we=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as a read |
| disp_valid | output | 1 | One-cycle strobe announcing a new character |
| disp_char | output | 8 | Character to display, held until the next accepted write |
| disp_done | input | 1 | One-cycle pulse from the display when it has finished the character |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover the reset state, one full send-and-done round trip, and a burst of data writes while busy. The burst separates dropping a write from overwriting the character. Status writes of all-ones and all-zeros while busy and while idle show whether bit 14 is the only field that moves. Done pulses that arrive while already ready show whether ready can be set twice or out of turn. Seeded random traffic then mixes reads, writes, foreign addresses and done pulses in every cycle against a reference model, so that coincidences appear: a write landing on the cycle after done, or a status write on the same edge as done.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/dsp_decode.sv
module dsp_decode
  import dsp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          hit,
  output logic              wr_stat,
  output logic              wr_data,
  output logic              rd_en
);
  always_comb begin
    hit = SEL_NONE;
    if (sel) begin
      if (addr == STAT_ADDR)      hit = SEL_STAT;
      else if (addr == DATA_ADDR) hit = SEL_DATA;
    end
  end

  assign wr_stat = we && (hit == SEL_STAT);
  assign wr_data = we && (hit == SEL_DATA);
  assign rd_en   = sel && !we;
endmodule

// File: rtl/dsp_ctrl.sv
module dsp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stat,
  input  logic wr_data,
  input  logic ie_wbit,
  input  logic done,
  output logic ready,
  output logic ie,
  output logic accept,
  output logic strobe,
  output logic irq
);
  assign accept = wr_data && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready  <= 1'b1;
      ie     <= 1'b0;
      strobe <= 1'b0;
    end else begin
      strobe <= accept;
      if (accept)           ready <= 1'b0;
      else if (done && !ready) ready <= 1'b1;
      if (wr_stat)          ie <= ie_wbit;
    end
  end

  assign irq = ready && ie;

  // R3
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!ready && strobe));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R5
  done_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ready) |=> ready);

  // R6
  stat_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wr_data && !done) |=> $stable(ready));
endmodule

// File: rtl/dsp_data.sv
module dsp_data #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] wchar,
  output logic [CHAR_W-1:0] char_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    char_q <= '0;
    else if (load) char_q <= wchar;
  end
endmodule

// File: rtl/dsp_port.sv
module dsp_port
  import dsp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int CHAR_W    = 8,
  parameter int READY_BIT = 15,
  parameter int IE_BIT    = 14,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_done,
  output logic              irq
);
  reg_sel_e hit;
  logic wr_stat, wr_data, rd_en;
  logic ready, ie, accept;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata;

  dsp_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .hit(hit), .wr_stat(wr_stat), .wr_data(wr_data), .rd_en(rd_en)
  );

  dsp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_data(wr_data),
    .ie_wbit(bus_wdata[IE_BIT]), .done(disp_done),
    .ready(ready), .ie(ie), .accept(accept), .strobe(disp_valid), .irq(irq)
  );

  dsp_data #(.CHAR_W(CHAR_W)) u_data (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .wchar(bus_wdata[CHAR_W-1:0]), .char_q(disp_char)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (hit)
        SEL_STAT: begin
          bus_rdata[READY_BIT] = ready;
          bus_rdata[IE_BIT]    = ie;
        end
        SEL_DATA: bus_rdata[CHAR_W-1:0] = disp_char;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == DATA_ADDR && !ready) |=> ($stable(disp_char) && !disp_valid));

  // R7
  irq_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !irq);

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || bus_we) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_dsp_port.sv
module sim_dsp_port;
  localparam logic [15:0] STAT = 16'hFE04;
  localparam logic [15:0] DATA = 16'hFE06;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0, disp_done = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic disp_valid, irq;
  logic [7:0] disp_char;

  int total = 0, bad = 0;
  logic m_ready = 1'b1, m_ie = 1'b0, m_valid = 1'b0;
  logic [7:0] m_char = 8'h00;

  always #4 clk = ~clk;

  dsp_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .disp_valid(disp_valid), .disp_char(disp_char), .disp_done(disp_done), .irq(irq)
  );

  function automatic logic [15:0] exp_read(logic s, logic w, logic [15:0] a);
    if (!s || w) return 16'h0000;
    if (a == STAT) return {m_ready, m_ie, 14'h0000};
    if (a == DATA) return {8'h00, m_char};
    return 16'h0000;
  endfunction

  function automatic string read_tag(logic s, logic w, logic [15:0] a);
    if (!s || w) return "R10";
    if (a == STAT) return "R2";
    if (a == DATA) return "R8";
    return "R9";
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [15:0] a,
                     input logic [15:0] d, input logic dn);
    logic acc;
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; disp_done = dn;
    #1;
    chk(bus_rdata, exp_read(s, w, a), read_tag(s, w, a));
    @(posedge clk);
    acc = s && w && (a == DATA) && m_ready;
    if (dn && !m_ready) m_ready = 1'b1;
    if (acc) begin m_ready = 1'b0; m_char = d[7:0]; end
    m_valid = acc;
    if (s && w && a == STAT) m_ie = d[14];
    #1;
    chk({15'h0, disp_valid}, {15'h0, m_valid}, "R3/R4 valid");
    chk({8'h00, disp_char}, {8'h00, m_char}, "R3/R4 char");
    chk({15'h0, irq}, {15'h0, m_ready && m_ie}, "R7");
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk({15'h0, disp_valid}, 16'h0, "R1");
    chk({15'h0, irq}, 16'h0, "R1");
    chk({8'h00, disp_char}, 16'h0, "R1");
    cyc(1, 0, STAT, 16'h0, 0);          // R1/R2: reads 8000
    cyc(1, 0, DATA, 16'h0, 0);          // R8 reads 0
    // R3 accepted write
    cyc(1, 1, DATA, 16'hAB41, 0);
    cyc(1, 0, STAT, 16'h0, 0);          // ready 0
    // R4 writes while busy dropped
    cyc(1, 1, DATA, 16'h0042, 0);
    cyc(1, 1, DATA, 16'h0043, 0);
    cyc(1, 0, DATA, 16'h0, 0);          // R8 still 41
    // R6 status write while busy: only ie moves
    cyc(1, 1, STAT, 16'hFFFF, 0);
    cyc(1, 0, STAT, 16'h0, 0);
    // R5 done restores ready, R7 irq rises
    cyc(0, 0, 16'h0, 16'h0, 1);
    cyc(1, 0, STAT, 16'h0, 0);
    // R5 done while ready ignored
    cyc(0, 0, 16'h0, 16'h0, 1);
    cyc(1, 1, STAT, 16'h0000, 0);       // R6 clear ie, ready kept
    cyc(1, 0, STAT, 16'h0, 0);
    // R9 foreign address
    cyc(1, 1, 16'hFE05, 16'hFFFF, 0);
    cyc(1, 0, 16'hFE05, 16'h0, 0);
    cyc(1, 1, DATA, 16'h007A, 1);       // done with ready=1 ignored, write accepted
    cyc(1, 1, STAT, 16'h4000, 1);       // R5 done and R6 status write on one edge
    cyc(1, 0, STAT, 16'h0, 0);
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int r = $urandom % 8;
      a = (r < 3) ? DATA : (r < 6) ? STAT : (r == 6) ? 16'hFE02 : 16'h1234;
      cyc($urandom % 4 != 0, $urandom % 2 == 1, a, 16'($urandom), ($urandom % 4) == 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule